// File: doc/BRIEF.md
# Watchpoint-Triggered Trace Recorder

The recorder captures CPU probe samples into an on-chip circular buffer. Each sample holds a program counter value together with a system bus access descriptor: address, data and direction. A sample is captured only in cycles where the probe-valid strobe is high and recording is active. Once the buffer is full, each new sample overwrites the oldest one.

A set of watchpoint comparators inspects every valid probe sample. Each watchpoint matches a masked value against either the PC or the bus address. A match can start recording, stop recording (which freezes the history), or raise a sticky processor halt request. System firmware writes identifiers, such as context-switch tags, into a small log register bank.

A separate debug port reads and writes the control state, the watchpoint setup, the log bank and the buffer. That port shares nothing with the system bus, so a remote controller can still recover the history after the CPU or the bus has hung. Buffer reads are rotated so that index 0 is the slot the next write will use, which gives oldest-to-newest order once the buffer has wrapped.

Top module: `trace_recorder`

## Requirements
- R1: After reset, recording is off, the halt request is low, the write pointer is 0, the wrap flag is 0, and every log register reads 0.
- R2: A sample {pc, addr, data, write} is stored at the write pointer, and the pointer increments modulo DEPTH, only when probe_valid is high and recording is active. Cycles with probe_valid low store nothing.
- R3: When the pointer steps from DEPTH-1 to 0, a sticky wrap flag sets. A debug read of buffer index i at address 0x200+4*i+f returns the slot at (pointer+i) mod DEPTH. Field f selects the value: 0 is pc, 1 is addr, 2 is data, and 3 is the direction bit in bit 0.
- R4: A stop action (code 2) stores the triggering sample if recording was on, then turns recording off. Later valid samples are not stored.
- R5: A start action (code 1) turns recording on, and the triggering sample is itself stored.
- R6: A halt action (code 3) sets halt_req. It stays high until a debug write to the control register at 0x000 with bit 1 set. A halt match leaves the recording state unchanged.
- R7: Watchpoint i is configured at 0x010+4*i. Offset +0 holds the compare value, +1 the mask, and +2 the config: bits[1:0] are the action, and bit 2 selects the source (0 = pc, 1 = bus address). The watchpoint matches when (source XOR value) AND mask is zero and its action is nonzero. All of these registers read back what was written.
- R8: When several watchpoints match one sample, only the lowest-numbered one acts.
- R9: A debug write to the control register sets recording to bit 0. If bit 2 is set, the same write clears the pointer and the wrap flag. A read of the control register returns {wrap, halt, recording} in bits 2:0. The pointer reads at 0x001.
- R10: Firmware writes log register sys_log_sel through the system-side port. The debug port reads log register j at 0x020+j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| probe_valid | input | 1 | Probe sample strobe |
| probe_pc | input | W | Program counter probe |
| probe_addr | input | W | Bus access address |
| probe_data | input | W | Bus access data |
| probe_write | input | 1 | Bus access direction (1 = write) |
| sys_log_we | input | 1 | Firmware log write strobe |
| sys_log_sel | input | LOG_AW | Firmware log register select |
| sys_log_data | input | W | Firmware log value |
| dbg_we | input | 1 | Debug port write strobe |
| dbg_addr | input | DBG_AW | Debug port address |
| dbg_wdata | input | W | Debug port write data |
| dbg_rdata | output | W | Debug port read data (combinational) |
| halt_req | output | 1 | Processor halt request |

## Verification
The bench builds the recorder with DEPTH=8, NUM_WP=2, LOGS=4 and W=16. With that setup, twelve samples are enough to wrap the buffer. After every phase, each buffer index and all four fields are swept against a model computed in the bench. Two watchpoints are enough to set a start action against a stop action, and then against a halt action, in the same cycle, so the priority rule is exercised. They also cover both source selects and a partial mask.

// File: rtl/trace_recorder.sv
module trace_recorder #(
  parameter int W      = 16,
  parameter int DEPTH  = 64,
  parameter int NUM_WP = 4,
  parameter int LOGS   = 8,
  parameter int LOG_AW = $clog2(LOGS),
  parameter int DBG_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              probe_valid,
  input  logic [W-1:0]      probe_pc,
  input  logic [W-1:0]      probe_addr,
  input  logic [W-1:0]      probe_data,
  input  logic              probe_write,
  input  logic              sys_log_we,
  input  logic [LOG_AW-1:0] sys_log_sel,
  input  logic [W-1:0]      sys_log_data,
  input  logic              dbg_we,
  input  logic [DBG_AW-1:0] dbg_addr,
  input  logic [W-1:0]      dbg_wdata,
  output logic [W-1:0]      dbg_rdata,
  output logic              halt_req
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [1:0] ACT_START = 2'd1, ACT_STOP = 2'd2, ACT_HALT = 2'd3;

  logic [W-1:0] m_pc [DEPTH];
  logic [W-1:0] m_ad [DEPTH];
  logic [W-1:0] m_da [DEPTH];
  logic         m_wr [DEPTH];

  logic [W-1:0] wp_val [NUM_WP];
  logic [W-1:0] wp_msk [NUM_WP];
  logic         wp_src [NUM_WP];
  logic [1:0]   wp_act [NUM_WP];
  logic [W-1:0] log_q  [LOGS];

  logic [IW-1:0] wptr, phys;
  logic wrap, rec;
  logic [1:0] act, hit;

  always_comb begin
    act = 2'd0;
    for (int i = NUM_WP - 1; i >= 0; i--)
      if (wp_act[i] != 2'd0 &&
          (((wp_src[i] ? probe_addr : probe_pc) ^ wp_val[i]) & wp_msk[i]) == '0)
        act = wp_act[i];
  end

  assign hit = probe_valid ? act : 2'd0;

  wire ctrl_wr = dbg_we && dbg_addr == '0;
  wire clr_buf = ctrl_wr && dbg_wdata[2];
  wire store   = probe_valid && (rec || hit == ACT_START);
  wire wp_sel  = dbg_addr[DBG_AW-1:4] == 1;
  wire log_sel = dbg_addr[DBG_AW-1:5] == 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec <= 1'b0; halt_req <= 1'b0; wptr <= '0; wrap <= 1'b0;
    end else begin
      if (ctrl_wr)               rec <= dbg_wdata[0];
      else if (hit == ACT_START) rec <= 1'b1;
      else if (hit == ACT_STOP)  rec <= 1'b0;

      if (hit == ACT_HALT)               halt_req <= 1'b1;
      else if (ctrl_wr && dbg_wdata[1])  halt_req <= 1'b0;

      if (clr_buf) begin
        wptr <= '0; wrap <= 1'b0;
      end else if (store) begin
        wptr <= wptr + 1'b1;
        if (&wptr) wrap <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (store) begin
      m_pc[wptr] <= probe_pc;
      m_ad[wptr] <= probe_addr;
      m_da[wptr] <= probe_data;
      m_wr[wptr] <= probe_write;
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WP; i++) begin
        wp_val[i] <= '0; wp_msk[i] <= '0; wp_src[i] <= 1'b0; wp_act[i] <= 2'd0;
      end
      for (int j = 0; j < LOGS; j++) log_q[j] <= '0;
    end else begin
      for (int i = 0; i < NUM_WP; i++)
        if (dbg_we && wp_sel && dbg_addr[3:2] == 2'(i))
          case (dbg_addr[1:0])
            2'd0: wp_val[i] <= dbg_wdata;
            2'd1: wp_msk[i] <= dbg_wdata;
            2'd2: {wp_src[i], wp_act[i]} <= dbg_wdata[2:0];
            default: ;
          endcase
      for (int j = 0; j < LOGS; j++)
        if (sys_log_we && sys_log_sel == LOG_AW'(j)) log_q[j] <= sys_log_data;
    end
  end

  assign phys = wptr + dbg_addr[IW+1:2];

  always_comb begin
    dbg_rdata = '0;
    if (dbg_addr[DBG_AW-1]) begin
      case (dbg_addr[1:0])
        2'd0: dbg_rdata = m_pc[phys];
        2'd1: dbg_rdata = m_ad[phys];
        2'd2: dbg_rdata = m_da[phys];
        default: dbg_rdata = W'(m_wr[phys]);
      endcase
    end else if (dbg_addr == '0) begin
      dbg_rdata = W'({wrap, halt_req, rec});
    end else if (dbg_addr == 1) begin
      dbg_rdata = W'(wptr);
    end else if (wp_sel) begin
      for (int i = 0; i < NUM_WP; i++)
        if (dbg_addr[3:2] == 2'(i))
          case (dbg_addr[1:0])
            2'd0: dbg_rdata = wp_val[i];
            2'd1: dbg_rdata = wp_msk[i];
            2'd2: dbg_rdata = W'({wp_src[i], wp_act[i]});
            default: ;
          endcase
    end else if (log_sel) begin
      for (int j = 0; j < LOGS; j++)
        if (dbg_addr[4:0] == 5'(j)) dbg_rdata = log_q[j];
    end
  end
endmodule

module trace_recorder_chk #(parameter int IW = 6) (
  input logic          clk,
  input logic          rst_n,
  input logic          probe_valid,
  input logic          dbg_we,
  input logic [IW-1:0] wptr,
  input logic          wrap,
  input logic          rec,
  input logic          halt_req,
  input logic          clr_halt
);
  p_wptr_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !probe_valid && !dbg_we |=> $stable(wptr));
  p_wrap_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && !dbg_we |=> wrap);
  p_rec_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rec) |-> $past(probe_valid || dbg_we));
  p_rec_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec) |-> $past(probe_valid || dbg_we));
  p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req && !clr_halt |=> halt_req);
  p_halt_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> $past(probe_valid));
endmodule

bind trace_recorder trace_recorder_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .probe_valid(probe_valid), .dbg_we(dbg_we),
  .wptr(wptr), .wrap(wrap), .rec(rec), .halt_req(halt_req),
  .clr_halt(ctrl_wr && dbg_wdata[1])
);

// File: tb/trace_recorder_test.sv
`timescale 1ns/1ps
module trace_recorder_test;
  localparam int W = 16, D = 8, NWP = 2, NL = 4, LAW = 2, AW = 10;

  logic clk = 0, rst_n = 0;
  logic probe_valid = 0, probe_write = 0, sys_log_we = 0, dbg_we = 0;
  logic [W-1:0] probe_pc = 0, probe_addr = 0, probe_data = 0, sys_log_data = 0, dbg_wdata = 0;
  logic [LAW-1:0] sys_log_sel = 0;
  logic [AW-1:0] dbg_addr = 0;
  logic [W-1:0] dbg_rdata;
  logic halt_req;

  trace_recorder #(.W(W), .DEPTH(D), .NUM_WP(NWP), .LOGS(NL), .LOG_AW(LAW), .DBG_AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .probe_valid(probe_valid), .probe_pc(probe_pc),
    .probe_addr(probe_addr), .probe_data(probe_data), .probe_write(probe_write),
    .sys_log_we(sys_log_we), .sys_log_sel(sys_log_sel), .sys_log_data(sys_log_data),
    .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata), .halt_req(halt_req));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [W-1:0] mpc[D], mad[D], mda[D];
  logic mwr[D], mval[D];
  int mwp = 0;
  logic mwrap = 0, mrec = 0, mhalt = 0;
  logic [W-1:0] wv[NWP], wm[NWP];
  logic ws[NWP];
  logic [1:0] wa[NWP];

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(string req, logic [AW-1:0] a, logic [W-1:0] exp);
    dbg_addr = a; #1;
    chk(req, dbg_rdata, exp);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [W-1:0] d);
    @(negedge clk); dbg_we = 1; dbg_addr = a; dbg_wdata = d;
    @(negedge clk); dbg_we = 0;
  endtask

  task automatic wctrl(logic [2:0] v);
    wr(0, W'(v));
    mrec = v[0];
    if (v[1]) mhalt = 0;
    if (v[2]) begin mwp = 0; mwrap = 0; end
  endtask

  task automatic wcfg(int i, logic [W-1:0] v, logic [W-1:0] m, logic s, logic [1:0] a);
    wr(AW'(16 + 4*i), v); wr(AW'(17 + 4*i), m); wr(AW'(18 + 4*i), W'({s, a}));
    wv[i] = v; wm[i] = m; ws[i] = s; wa[i] = a;
  endtask

  task automatic smp(logic v, logic [W-1:0] pc, logic [W-1:0] ad, logic [W-1:0] da, logic w);
    logic [1:0] act;
    @(negedge clk);
    probe_valid = v; probe_pc = pc; probe_addr = ad; probe_data = da; probe_write = w;
    act = 0;
    for (int i = NWP - 1; i >= 0; i--)
      if (wa[i] != 0 && (((ws[i] ? ad : pc) ^ wv[i]) & wm[i]) == 0) act = wa[i];
    if (v) begin
      if (mrec || act == 1) begin
        mpc[mwp] = pc; mad[mwp] = ad; mda[mwp] = da; mwr[mwp] = w; mval[mwp] = 1;
        if (mwp == D - 1) mwrap = 1;
        mwp = (mwp + 1) % D;
      end
      if (act == 1) mrec = 1;
      if (act == 2) mrec = 0;
      if (act == 3) mhalt = 1;
    end
    @(negedge clk); probe_valid = 0;
  endtask

  task automatic check_all(string req);
    rd(req, 0, W'({mwrap, mhalt, mrec}));
    rd(req, 1, W'(mwp));
    chk(req, W'(halt_req), W'(mhalt));
    for (int i = 0; i < D; i++) begin
      int p = (mwp + i) % D;
      if (mval[p]) begin
        rd(req, AW'(512 + 4*i), mpc[p]);
        rd(req, AW'(513 + 4*i), mad[p]);
        rd(req, AW'(514 + 4*i), mda[p]);
        rd(req, AW'(515 + 4*i), W'(mwr[p]));
      end
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < D; i++) mval[i] = 0;
    for (int i = 0; i < NWP; i++) begin wv[i] = 0; wm[i] = 0; ws[i] = 0; wa[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check_all("R1");
    for (int j = 0; j < NL; j++) rd("R1", AW'(32 + j), 0);
    // R10 firmware log bank
    for (int j = 0; j < NL; j++) begin
      @(negedge clk); sys_log_we = 1; sys_log_sel = LAW'(j); sys_log_data = W'(16'hC0DE ^ (j * 16'h1111));
    end
    @(negedge clk); sys_log_we = 0;
    for (int j = 0; j < NL; j++) rd("R10", AW'(32 + j), W'(16'hC0DE ^ (j * 16'h1111)));
    // R2 capture only on valid cycles while recording
    smp(1, 16'h0100, 16'h0200, 16'h0300, 1);
    check_all("R2");
    wctrl(3'b001);
    for (int k = 0; k < 5; k++) begin
      smp(1, W'(16'h1000 + k), W'(16'h2000 + 3*k), W'(16'h7000 ^ k), k[0]);
      smp(0, W'(16'hDEAD + k), W'(16'hBEEF), W'(k), 1);
    end
    check_all("R2");
    // R3 wrap, overwrite and rotated readout
    for (int k = 5; k < 12; k++) smp(1, W'(16'h1000 + k), W'(16'h2000 + 3*k), W'(16'h7000 ^ k), k[1]);
    check_all("R3");
    // R9 direct control: stop and clear
    wctrl(3'b100);
    check_all("R9");
    smp(1, 16'h4444, 16'h5555, 16'h6666, 0);
    check_all("R9");
    // R7 configuration readback
    wcfg(0, 16'h1234, 16'hFFFF, 0, 2'd2);
    wcfg(1, 16'h00A0, 16'h00F0, 1, 2'd1);
    for (int i = 0; i < NWP; i++) begin
      rd("R7", AW'(16 + 4*i), wv[i]);
      rd("R7", AW'(17 + 4*i), wm[i]);
      rd("R7", AW'(18 + 4*i), W'({ws[i], wa[i]}));
    end
    // R7 masked non-match, R5 start
    smp(1, 16'h00A0, 16'h05B0, 16'h0001, 0);
    check_all("R7");
    smp(1, 16'h0011, 16'h05A7, 16'h0002, 1);
    check_all("R5");
    smp(1, 16'h0012, 16'h0000, 16'h0003, 0);
    // R4 stop freezes
    smp(1, 16'h1234, 16'h0001, 16'h0004, 1);
    check_all("R4");
    smp(1, 16'h0013, 16'h0002, 16'h0005, 0);
    smp(1, 16'h0014, 16'h00A1, 16'h0006, 0);
    check_all("R4");
    // R8 stop (wp0) beats start (wp1)
    wctrl(3'b000);
    smp(1, 16'h1234, 16'h00A5, 16'h0007, 0);
    check_all("R8");
    // R6 halt beats start, rec unchanged, sticky until cleared
    wcfg(0, 16'h1234, 16'hFFFF, 0, 2'd3);
    smp(1, 16'h1234, 16'h00A5, 16'h0008, 1);
    check_all("R6");
    repeat (5) @(negedge clk);
    chk("R6", W'(halt_req), 1);
    wctrl(3'b001);
    chk("R6", W'(halt_req), 1);
    wctrl(3'b010);
    check_all("R6");
    finish_run();
  end
endmodule